// File: doc/BRIEF.md
# CCM CBC-MAC Authentication Unit

This unit produces the authentication tag of a CCM transaction. It builds the CBC-MAC block sequence and walks through it one block at a time. First comes the header block, which holds the flags, the nonce and the message length. Next come two additional-data blocks, and then the message blocks. Each block is handed to an external 128-bit block cipher over a start/done handshake. The block is XORed with the previous cipher output first, except for the header block, which goes to the cipher unchanged. The last cipher output is cut to the tag length and registered.

A top-level controller pulses `start`. From then on, a local step counter runs the whole walk. On each step it emits a 5-bit control word with these fields:
- a chaining-register enable
- a cipher start
- a select for XOR or direct input
- a 2-bit block type

Message blocks are read from an external synchronous memory through a block index. A mode input chooses the source of the message: the sender's plaintext when authenticating, or the plaintext recovered by decryption when verifying. All data inputs must stay stable from `start` until `done`.

Top module: `ccm_cbcmac_auth`

## Requirements
- R1: While `rst` is high, and after it is released, `done`, `cph_start` and `tag` are 0 and `msg_idx` is 0.
- R2: The first block sent to the cipher is the header block, passed with no XOR. Byte 0 (bits 127:120) holds the flags: bit 6 = 1, bits 5:3 = (tag_len-2)/2, bits 2:0 = L-1 = 1. Bytes 1..13 hold `nonce`, with byte 1 at `nonce[103:96]`. Bytes 14..15 hold `msg_len`, big-endian.
- R3: Blocks 2 and 3 are formed from a 32-byte string: `ad_len` as a 16-bit big-endian value, followed by the 30 bytes of `ad_data` (byte 0 at `ad_data[239:232]`). Bytes at index `ad_len` and above are zeroed. Block 2 is bytes 0..15 of the string and block 3 is bytes 16..31.
- R4: Every block after the first is sent as `Xi XOR Bi`, where Xi is the cipher result of the block before.
- R5: The message gives ceil(msg_len/16) blocks, and none when `msg_len` is 0. In a final partial block, bytes at index msg_len mod 16 and above are zeroed.
- R6: `tag` holds the final cipher result with bytes 0..tag_len-1 kept and all later bytes zero.
- R7: When `mode` is 0 message blocks come from `pt_blk`; when `mode` is 1 they come from `rec_blk`.
- R8: `cph_start` is a one-cycle pulse. No new pulse occurs until `cph_done` for the previous block, and `cph_block` stays stable while the cipher is busy.
- R9: A `start` pulse while a computation is running has no effect.
- R10: `done` is a one-cycle pulse. `tag` keeps its value until the next completion.
- R11: `msg_idx` names message block k (counted from 0) while block k is being fetched. Exactly 3 + ceil(msg_len/16) cipher operations occur per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one authentication run |
| mode | input | 1 | 0: authenticate plaintext, 1: verify recovered plaintext |
| tag_len | input | 5 | Tag length M in bytes (4..16, even) |
| nonce | input | 104 | Nonce, 13 bytes |
| ad_len | input | 5 | Additional-data length in bytes (0..30) |
| ad_data | input | 240 | Additional-data bytes |
| msg_len | input | 11 | Message length in bytes (0..1024) |
| msg_idx | output | 6 | Index of the message block to read |
| pt_blk | input | 128 | Plaintext block, one cycle after the index |
| rec_blk | input | 128 | Recovered plaintext block, one cycle after the index |
| cph_start | output | 1 | Cipher start pulse |
| cph_block | output | 128 | Block to encipher |
| cph_done | input | 1 | Cipher result valid |
| cph_result | input | 128 | Cipher output |
| tag | output | 128 | Truncated tag |
| done | output | 1 | Tag ready pulse |

## Verification
The bench pairs the unit with a nonlinear stand-in cipher and tries it with several message lengths:
- Two full blocks.
- A 21-byte message, which exposes the tail padding.
- An empty message, which must skip the message phase.
- The full 1024 bytes, which reaches the top of the index range.

Additional-data lengths of 0, 5, 14 and 30 tell apart masking errors in the first and second additional-data blocks. Tag lengths of 4, 8, 10 and 16 separate truncation faults. A verify run with different plaintext and recovered data shows whether the mode mux picks the right source. A second `start` pulse in the middle of a run shows whether a busy unit ignores it.

// File: rtl/ccm_auth_pkg.sv
package ccm_auth_pkg;
  localparam int BLK_W = 128;
  localparam int BLK_BYTES = BLK_W / 8;

  typedef enum logic [1:0] {
    BT_HDR = 2'b00,
    BT_AD  = 2'b01,
    BT_MSG = 2'b10
  } blk_type_e;

  // 5-bit control word, bit 0 is chain_en
  typedef struct packed {
    blk_type_e btype;    // bits 4:3
    logic      xor_sel;  // bit 2
    logic      cph_go;   // bit 1
    logic      chain_en; // bit 0
  } ctl_word_t;
endpackage

// File: rtl/ccm_auth_seq.sv
module ccm_auth_seq
  import ccm_auth_pkg::*;
#(
  parameter int MAX_BLK = 64,
  parameter int AD_BLKS = 2,
  parameter int IDX_W   = $clog2(MAX_BLK),
  parameter int LEN_W   = $clog2(MAX_BLK * 16 + 1),
  parameter int STEP_W  = $clog2(MAX_BLK + AD_BLKS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             cph_done,
  output ctl_word_t        cw,
  output logic [IDX_W-1:0] msg_idx,
  output logic             ad_second,
  output logic             last_msg,
  output logic             finish
);
  localparam int NBLK_W = LEN_W - 3;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ISSUE, S_WAIT} state_e;

  state_e             state;
  logic [STEP_W-1:0]  step;
  logic [LEN_W:0]     len_rnd;
  logic [NBLK_W-1:0]  nmsg;
  logic [STEP_W-1:0]  last_step;
  blk_type_e          btype;

  assign len_rnd   = {1'b0, msg_len} + (LEN_W+1)'(15);
  assign nmsg      = len_rnd[LEN_W:4];
  assign last_step = STEP_W'(nmsg) + STEP_W'(AD_BLKS);

  always_comb begin
    if (step == '0)                          btype = BT_HDR;
    else if (step <= STEP_W'(AD_BLKS))       btype = BT_AD;
    else                                     btype = BT_MSG;
  end

  assign ad_second   = (step == STEP_W'(AD_BLKS));
  assign last_msg    = ((NBLK_W'(msg_idx) + NBLK_W'(1)) == nmsg);
  assign cw.btype    = btype;
  assign cw.xor_sel  = (step != '0);
  assign cw.cph_go   = (state == S_ISSUE);
  assign cw.chain_en = (state == S_WAIT);
  assign finish      = (state == S_WAIT) && cph_done && (step == last_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      step    <= '0;
      msg_idx <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          step    <= '0;
          msg_idx <= '0;
          state   <= S_PREP;
        end
        S_PREP:  state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (cph_done) begin
          if (step == last_step) begin
            state <= S_IDLE;
          end else begin
            step  <= step + STEP_W'(1);
            state <= S_PREP;
          end
          if (btype == BT_MSG) msg_idx <= msg_idx + IDX_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccm_blk_fmt.sv
module ccm_blk_fmt
  import ccm_auth_pkg::*;
#(
  parameter int L_BYTES  = 2,
  parameter int NONCE_W  = 8 * (15 - L_BYTES),
  parameter int AD_BYTES = 30,
  parameter int AD_LW    = $clog2(AD_BYTES + 1),
  parameter int LEN_W    = 11
) (
  input  blk_type_e             btype,
  input  logic                  ad_second,
  input  logic                  last_msg,
  input  logic [4:0]            tag_len,
  input  logic [NONCE_W-1:0]    nonce,
  input  logic [LEN_W-1:0]      msg_len,
  input  logic [AD_LW-1:0]      ad_len,
  input  logic [8*AD_BYTES-1:0] ad_data,
  input  logic [BLK_W-1:0]      msg_blk,
  output logic [BLK_W-1:0]      blk
);
  localparam int AD_STR_W = 16 + 8 * AD_BYTES;

  logic [7:0]              flags;
  logic [2:0]              m_fld;
  logic [8*AD_BYTES-1:0]   ad_mask;
  logic [AD_STR_W-1:0]     ad_str;
  logic [BLK_W-1:0]        msg_pad;
  logic [3:0]              tail;

  assign m_fld = 3'((tag_len - 5'd2) >> 1);
  assign flags = {1'b0, 1'b1, m_fld, 3'(L_BYTES - 1)};
  assign tail  = msg_len[3:0];

  always_comb begin
    for (int j = 0; j < AD_BYTES; j++) begin
      ad_mask[8*AD_BYTES-1-8*j -: 8] =
        (j < int'(ad_len)) ? ad_data[8*AD_BYTES-1-8*j -: 8] : 8'h00;
    end
  end

  assign ad_str = {16'(ad_len), ad_mask};

  always_comb begin
    for (int j = 0; j < BLK_BYTES; j++) begin
      msg_pad[BLK_W-1-8*j -: 8] =
        (last_msg && tail != 4'd0 && j >= int'(tail)) ? 8'h00
                                                      : msg_blk[BLK_W-1-8*j -: 8];
    end
  end

  always_comb begin
    unique case (btype)
      BT_HDR:  blk = {flags, nonce, (8*L_BYTES)'(msg_len)};
      BT_AD:   blk = ad_second ? ad_str[BLK_W-1:0] : ad_str[AD_STR_W-1 -: BLK_W];
      default: blk = msg_pad;
    endcase
  end
endmodule

// File: rtl/ccm_mac_chain.sv
module ccm_mac_chain
  import ccm_auth_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctl_word_t        cw,
  input  logic [BLK_W-1:0] blk,
  input  logic             cph_done,
  input  logic [BLK_W-1:0] cph_result,
  input  logic             finish,
  input  logic [4:0]       tag_len,
  output logic             cph_start,
  output logic [BLK_W-1:0] cph_block,
  output logic [BLK_W-1:0] tag,
  output logic             done
);
  logic [BLK_W-1:0] chain;
  logic [BLK_W-1:0] trunc;

  always_comb begin
    for (int j = 0; j < BLK_BYTES; j++) begin
      trunc[BLK_W-1-8*j -: 8] = (j < int'(tag_len)) ? cph_result[BLK_W-1-8*j -: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain     <= '0;
      cph_start <= 1'b0;
      cph_block <= '0;
      tag       <= '0;
      done      <= 1'b0;
    end else begin
      cph_start <= cw.cph_go;
      done      <= finish;
      if (cw.cph_go) cph_block <= cw.xor_sel ? (chain ^ blk) : blk;
      if (cw.chain_en && cph_done) chain <= cph_result;
      if (finish) tag <= trunc;
    end
  end
endmodule

// File: rtl/ccm_cbcmac_auth.sv
module ccm_cbcmac_auth
  import ccm_auth_pkg::*;
#(
  parameter int MAX_BLK  = 64,
  parameter int L_BYTES  = 2,
  parameter int AD_BYTES = 30,
  parameter int NONCE_W  = 8 * (15 - L_BYTES),
  parameter int IDX_W    = $clog2(MAX_BLK),
  parameter int LEN_W    = $clog2(MAX_BLK * 16 + 1),
  parameter int AD_LW    = $clog2(AD_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  mode,
  input  logic [4:0]            tag_len,
  input  logic [NONCE_W-1:0]    nonce,
  input  logic [AD_LW-1:0]      ad_len,
  input  logic [8*AD_BYTES-1:0] ad_data,
  input  logic [LEN_W-1:0]      msg_len,
  output logic [IDX_W-1:0]      msg_idx,
  input  logic [127:0]          pt_blk,
  input  logic [127:0]          rec_blk,
  output logic                  cph_start,
  output logic [127:0]          cph_block,
  input  logic                  cph_done,
  input  logic [127:0]          cph_result,
  output logic [127:0]          tag,
  output logic                  done
);
  ctl_word_t        cw;
  logic             ad_second;
  logic             last_msg;
  logic             finish;
  logic [BLK_W-1:0] msg_blk;
  logic [BLK_W-1:0] blk;

  assign msg_blk = mode ? rec_blk : pt_blk;

  ccm_auth_seq #(
    .MAX_BLK(MAX_BLK), .AD_BLKS(2), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .msg_len(msg_len), .cph_done(cph_done),
    .cw(cw), .msg_idx(msg_idx), .ad_second(ad_second), .last_msg(last_msg),
    .finish(finish)
  );

  ccm_blk_fmt #(
    .L_BYTES(L_BYTES), .NONCE_W(NONCE_W), .AD_BYTES(AD_BYTES), .AD_LW(AD_LW),
    .LEN_W(LEN_W)
  ) u_fmt (
    .btype(cw.btype), .ad_second(ad_second), .last_msg(last_msg),
    .tag_len(tag_len), .nonce(nonce), .msg_len(msg_len), .ad_len(ad_len),
    .ad_data(ad_data), .msg_blk(msg_blk), .blk(blk)
  );

  ccm_mac_chain u_chain (
    .clk(clk), .rst(rst), .cw(cw), .blk(blk), .cph_done(cph_done),
    .cph_result(cph_result), .finish(finish), .tag_len(tag_len),
    .cph_start(cph_start), .cph_block(cph_block), .tag(tag), .done(done)
  );
endmodule

// File: rtl/ccm_cbcmac_auth_chk.sv
module ccm_cbcmac_auth_chk (
  input logic         clk,
  input logic         rst,
  input logic         cph_start,
  input logic [127:0] cph_block,
  input logic         cph_done,
  input logic         done,
  input logic [127:0] tag,
  input logic [4:0]   tag_len
);
  logic pend;
  logic tag_hi_zero;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (cph_start) pend <= 1'b1;
    else if (cph_done) pend <= 1'b0;
  end

  always_comb begin
    tag_hi_zero = 1'b1;
    for (int j = 0; j < 16; j++) begin
      if (j >= int'(tag_len) && tag[127-8*j -: 8] != 8'h00) tag_hi_zero = 1'b0;
    end
  end

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cph_start |=> !cph_start);
  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
    cph_start |-> !pend);
  assert_block_stable_R8: assert property (@(posedge clk) disable iff (rst)
    pend |-> $stable(cph_block));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_tag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(tag));
  assert_tag_trunc_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> tag_hi_zero);
endmodule

bind ccm_cbcmac_auth ccm_cbcmac_auth_chk u_chk (
  .clk(clk), .rst(rst), .cph_start(cph_start), .cph_block(cph_block),
  .cph_done(cph_done), .done(done), .tag(tag), .tag_len(tag_len)
);

// File: tb/tb_ccm_cbcmac_auth.sv
module tb_ccm_cbcmac_auth;
  localparam int LAT = 4;
  localparam logic [127:0] KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [4:0]   tag_len = 5'd8;
  logic [103:0] nonce = '0;
  logic [4:0]   ad_len = '0;
  logic [239:0] ad_data = '0;
  logic [10:0]  msg_len = '0;
  logic [5:0]   msg_idx;
  logic [127:0] pt_blk, rec_blk;
  logic         cph_start;
  logic [127:0] cph_block;
  logic         cph_done;
  logic [127:0] cph_result;
  logic [127:0] tag;
  logic         done;

  always #2.5 clk = ~clk;

  ccm_cbcmac_auth dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .tag_len(tag_len),
    .nonce(nonce), .ad_len(ad_len), .ad_data(ad_data), .msg_len(msg_len),
    .msg_idx(msg_idx), .pt_blk(pt_blk), .rec_blk(rec_blk),
    .cph_start(cph_start), .cph_block(cph_block), .cph_done(cph_done),
    .cph_result(cph_result), .tag(tag), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  logic [127:0] exp_q[$];
  string        req_q[$];
  logic [127:0] tag_q[$];
  logic [127:0] last_tag;
  logic         done_prev = 1'b0;

  logic [127:0] pt_mem  [64];
  logic [127:0] rec_mem [64];

  function automatic logic [127:0] enc(input logic [127:0] x);
    enc = x ^ ({x[120:0], x[127:121]} & {x[108:0], x[127:109]})
            ^ {x[66:0], x[127:67]} ^ KEY;
  endfunction

  function automatic logic [127:0] trunc_t(input logic [127:0] x, input int m);
    for (int j = 0; j < 16; j++) if (j >= m) x[127-8*j -: 8] = 8'h00;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stand-in cipher with fixed latency
  int cnt = 0;
  logic [127:0] cbuf;
  always @(posedge clk) begin
    if (rst) begin
      cph_done <= 1'b0; cph_result <= '0; cnt <= 0;
    end else begin
      cph_done <= 1'b0;
      if (cph_start) begin
        cbuf <= enc(cph_block); cnt <= LAT;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin cph_done <= 1'b1; cph_result <= cbuf; end
      end
    end
  end

  // synchronous message memories
  always @(posedge clk) begin
    pt_blk  <= pt_mem[msg_idx];
    rec_blk <= rec_mem[msg_idx];
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cph_start) begin
        chk(cnt == 0, "R8 start while cipher busy", 128'(cnt), 0);
        if (exp_q.size() == 0) chk(0, "R9 unexpected cipher block", cph_block, 0);
        else begin
          logic [127:0] e; string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          chk(cph_block == e, r, cph_block, e);
        end
      end
      if (done) begin
        if (tag_q.size() == 0) chk(0, "R10 unexpected done", tag, 0);
        else begin
          logic [127:0] e;
          e = tag_q.pop_front();
          chk(tag == e, "R6 tag value", tag, e);
          last_tag = e;
        end
        done_cnt++;
      end
      if (done && done_prev) chk(0, "R10 done wider than one cycle", 1, 0);
      done_prev <= done;
    end
  end

  task automatic run_case(input bit md, input int len, input int m, input int al,
                          input logic [103:0] nn, input bit restart);
    logic [127:0] x, b, hdr;
    logic [255:0] s;
    logic [239:0] adm;
    int nblk, tgt;
    @(negedge clk);
    mode = md; msg_len = 11'(len); tag_len = 5'(m); ad_len = 5'(al); nonce = nn;
    adm = ad_data;
    for (int j = 0; j < 30; j++) if (j >= al) adm[239-8*j -: 8] = 8'h00;
    s = {16'(al), adm};
    hdr = {1'b0, 1'b1, 3'((m - 2) / 2), 3'd1, nn, 16'(len)};
    exp_q.push_back(hdr); req_q.push_back("R2 header block");
    x = enc(hdr);
    b = x ^ s[255:128]; exp_q.push_back(b); req_q.push_back("R3 first ad block");
    x = enc(b);
    b = x ^ s[127:0];   exp_q.push_back(b); req_q.push_back("R3 second ad block");
    x = enc(b);
    nblk = (len + 15) / 16;
    for (int k = 0; k < nblk; k++) begin
      logic [127:0] mb;
      mb = md ? rec_mem[k] : pt_mem[k];
      if (k == nblk - 1 && (len % 16) != 0) mb = trunc_t(mb, len % 16);
      b = x ^ mb;
      exp_q.push_back(b);
      req_q.push_back(md ? "R7 R4 R5 verify msg block" : "R4 R5 msg block");
      x = enc(b);
    end
    tag_q.push_back(trunc_t(x, m));
    tgt = done_cnt + 1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (7) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (done_cnt < tgt) @(negedge clk);
    chk(exp_q.size() == 0, "R11 block count", 128'(exp_q.size()), 0);
    repeat (4) @(negedge clk);
    chk(tag == trunc_t(x, m) && !done, "R10 tag held after done", tag, trunc_t(x, m));
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      pt_mem[k]  = {4{32'hA5000000 + 32'(k * 7919)}} ^ 128'(k);
      rec_mem[k] = {4{32'h3C000000 + 32'(k * 104729)}} ^ {k[7:0], 120'h0};
    end
    for (int j = 0; j < 30; j++) ad_data[239-8*j -: 8] = 8'(8'h11 + j * 13);
    repeat (4) @(negedge clk);
    chk(!done && !cph_start && tag == 0 && msg_idx == 0, "R1 reset state", tag, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !cph_start && tag == 0 && msg_idx == 0, "R1 after reset release", tag, 0);
    run_case(1'b0, 32,   8,  5, 104'h0102030405060708090a0b0c0d, 1'b0);
    run_case(1'b0, 21,   16, 30, 104'hffeeddccbbaa99887766554433, 1'b0);
    run_case(1'b1, 37,   4,  0, 104'h13579bdf02468ace13579bdf02, 1'b0);
    run_case(1'b0, 0,    10, 14, 104'h00000000000000000000000001, 1'b0);
    run_case(1'b0, 1024, 16, 9, 104'hdeadbeefcafef00d0123456789, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule